// File: doc/BRIEF.md
# Pointer-Selected Column Byte Streamer

This block moves a stream of bytes between a byte-wide port and a bank of column-block data lanes. It does not broadcast a column address. A single circulating one-hot token marks the active lane, so during a transfer only the token bits and the lane being touched change state. A transfer is launched by a one-cycle `start` pulse. The pulse carries the first column, the direction and the byte count. The token then walks through consecutive lanes until the count runs out, wrapping past the last lane back to lane 0.

Reads pass through a three-stage pickup pipeline:
- Every half-quadrant (eight lanes) is reduced to one byte.
- The top and bottom halves of each quadrant merge into one quadrant byte.
- The four quadrant bytes merge into the output register.

Writes pass through two staging registers before they reach the lane. A separate trailing use of the same token then steers each write into its lane. Backpressure on the read side freezes the token and all three read stages together.

Top module: `colstream_top`

## Requirements
- R1: While reset is held, and while no transfer is active, `out_valid`, `in_ready` and `busy` are 0.
- R2: In read mode (`dir_rd`=1) with `out_ready` held at 1, `out_valid` first rises on the third rising edge after the edge that samples `start`.
- R3: Read bytes come out in lane order `start_col`, `start_col`+1, and so on. Lane index = quadrant*16 + half*8 + local, with half 0 (top) before half 1 (bottom) and quadrants 0 to 3 in order. Exactly one lane is selected during a transfer.
- R4: After lane 63 the next lane is lane 0, for both reads and writes, and for counts that wrap more than once.
- R5: With `out_ready` held at 1, a read of N bytes yields N bytes on N consecutive cycles.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold on the next edge, and no byte is lost or repeated.
- R7: In write mode (`dir_rd`=0), the k-th byte accepted (`in_valid` and `in_ready` both 1) is stored in lane (`start_col`+k) mod 64. A later read returns it.
- R8: A transfer moves exactly `xfer_len` bytes. After that, `in_ready` and `out_valid` stay 0 and `busy` returns to 0. A `start` with `xfer_len`=0 launches nothing.
- R9: A `start` pulse while `busy`=1 is ignored. The running stream keeps its order and count, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a transfer when idle |
| start_col | input | 6 | First lane of the transfer |
| dir_rd | input | 1 | 1 = lanes to output, 0 = input to lanes |
| xfer_len | input | 7 | Number of bytes to move |
| in_valid | input | 1 | Write byte offered |
| in_ready | output | 1 | Write byte accepted this cycle |
| in_data | input | 8 | Write byte |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Read byte taken this cycle |
| out_data | output | 8 | Read byte |
| busy | output | 1 | Transfer or pipeline drain in progress |

## Verification
A wrong token position shows at the port as a read byte from the wrong lane, three cycles after the faulty step. A write landed in the wrong lane only shows when that lane is read back in a later transfer. A broken stall freeze shows one edge after `out_ready` drops, as a changed or skipped `out_data`. A wrong remaining-count shows at the end of the stream, as a missing or extra byte and a `busy` that clears too early or too late.

// File: rtl/colstream_pkg.sv
package colstream_pkg;
  localparam int CS_DATA_W  = 8;
  localparam int CS_NUM_BLK = 64;
  localparam int CS_NUM_QD  = 4;
  localparam int CS_LEN_W   = 7;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_RUN   = 2'd1,
    CS_DRAIN = 2'd2
  } cs_state_e;
endpackage

// File: rtl/cs_token_ring.sv
module cs_token_ring #(
  parameter int NUM_BLK = 64,
  parameter int COL_W   = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [COL_W-1:0]   load_col,
  input  logic               step,
  output logic [NUM_BLK-1:0] sel
);
  logic [NUM_BLK-1:0] sel_q, sel_d;

  // preset wins over advance; advance rotates the token one lane up
  always_comb begin
    sel_d = sel_q;
    if (load) begin
      sel_d = '0;
      sel_d[load_col] = 1'b1;
    end else if (step) begin
      sel_d = {sel_q[NUM_BLK-2:0], sel_q[NUM_BLK-1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign sel = sel_q;
endmodule

// File: rtl/cs_latch_bank.sv
module cs_latch_bank #(
  parameter int DATA_W  = 8,
  parameter int NUM_BLK = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [NUM_BLK-1:0]        wr_sel,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [NUM_BLK*DATA_W-1:0] lanes
);
  for (genvar i = 0; i < NUM_BLK; i++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    logic              lane_we;
    assign lane_we = wr_en & wr_sel[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_we) lane_q <= wr_data;
    end
    assign lanes[i*DATA_W +: DATA_W] = lane_q;
  end
endmodule

// File: rtl/cs_read_pipe.sv
module cs_read_pipe #(
  parameter int DATA_W  = 8,
  parameter int NUM_BLK = 64,
  parameter int NUM_QD  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issue,
  input  logic [NUM_BLK-1:0]        sel,
  input  logic [NUM_BLK*DATA_W-1:0] lanes,
  input  logic                      out_ready,
  output logic                      adv,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         out_data,
  output logic                      pipe_busy
);
  localparam int NUM_HALF = NUM_QD * 2;
  localparam int PER_HALF = NUM_BLK / NUM_HALF;

  logic [DATA_W-1:0] half_d [NUM_HALF];
  logic [DATA_W-1:0] half_q [NUM_HALF];
  logic [DATA_W-1:0] quad_d [NUM_QD];
  logic [DATA_W-1:0] quad_q [NUM_QD];
  logic [DATA_W-1:0] pick_d, pick_q;
  logic v1_q, v2_q, v3_q;

  // stage 1: each half-quadrant picks the lane its token bit marks
  // half index = quadrant*2 + half, half 0 = top
  always_comb begin
    for (int g = 0; g < NUM_HALF; g++) begin
      half_d[g] = '0;
      for (int l = 0; l < PER_HALF; l++) begin
        half_d[g] = half_d[g] |
          (lanes[(g*PER_HALF+l)*DATA_W +: DATA_W] & {DATA_W{sel[g*PER_HALF+l]}});
      end
    end
  end

  // stage 2: top and bottom of each quadrant merge
  always_comb begin
    for (int q = 0; q < NUM_QD; q++) quad_d[q] = half_q[2*q] | half_q[2*q+1];
  end

  // stage 3: the four quadrant pickups merge
  always_comb begin
    pick_d = '0;
    for (int q = 0; q < NUM_QD; q++) pick_d = pick_d | quad_q[q];
  end

  assign adv = !(v3_q && !out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
      pick_q <= '0;
      for (int g = 0; g < NUM_HALF; g++) half_q[g] <= '0;
      for (int q = 0; q < NUM_QD; q++)   quad_q[q] <= '0;
    end else if (adv) begin
      v1_q <= issue;
      v2_q <= v1_q;
      v3_q <= v2_q;
      pick_q <= pick_d;
      for (int g = 0; g < NUM_HALF; g++) half_q[g] <= half_d[g];
      for (int q = 0; q < NUM_QD; q++)   quad_q[q] <= quad_d[q];
    end
  end

  assign out_valid = v3_q;
  assign out_data  = pick_q;
  assign pipe_busy = v1_q | v2_q | v3_q;
endmodule

// File: rtl/cs_write_pipe.sv
module cs_write_pipe #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [DATA_W-1:0] din,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              pipe_busy
);
  logic              w1_v, w2_v;
  logic [DATA_W-1:0] w1_d, w2_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1_v <= 1'b0;
      w2_v <= 1'b0;
      w1_d <= '0;
      w2_d <= '0;
    end else begin
      w1_v <= fire;
      w2_v <= w1_v;
      if (fire) w1_d <= din;
      if (w1_v) w2_d <= w1_d;
    end
  end

  assign wr_en     = w2_v;
  assign wr_data   = w2_d;
  assign pipe_busy = w1_v | w2_v;
endmodule

// File: rtl/colstream_top.sv
module colstream_top
  import colstream_pkg::*;
#(
  parameter int DATA_W  = CS_DATA_W,
  parameter int NUM_BLK = CS_NUM_BLK,
  parameter int NUM_QD  = CS_NUM_QD,
  parameter int LEN_W   = CS_LEN_W,
  parameter int COL_W   = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              dir_rd,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              busy
);
  cs_state_e          state_q, state_d;
  logic [LEN_W-1:0]   rem_q, rem_d;
  logic               dir_q, dir_d;
  logic               start_ok, rd_issue, wr_fire, dec, adv;
  logic               rp_busy, wp_busy, wp_wr_en, tok_step;
  logic [DATA_W-1:0]  wp_wr_data;
  logic [NUM_BLK-1:0] tok_sel;
  logic [NUM_BLK*DATA_W-1:0] lanes;

  assign start_ok = (state_q == CS_IDLE) && start && (xfer_len != '0);
  assign in_ready = (state_q == CS_RUN) && !dir_q;
  assign wr_fire  = in_ready && in_valid;
  assign rd_issue = (state_q == CS_RUN) && dir_q && adv;
  assign dec      = rd_issue | wr_fire;
  assign tok_step = dir_q ? rd_issue : wp_wr_en;
  assign busy     = (state_q != CS_IDLE);

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    dir_d   = dir_q;
    unique case (state_q)
      CS_IDLE: if (start_ok) begin
        state_d = CS_RUN;
        rem_d   = xfer_len;
        dir_d   = dir_rd;
      end
      CS_RUN: if (dec) begin
        rem_d = rem_q - LEN_W'(1);
        if (rem_q == LEN_W'(1)) state_d = CS_DRAIN;
      end
      CS_DRAIN: if (!rp_busy && !wp_busy) state_d = CS_IDLE;
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      rem_q   <= '0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      dir_q   <= dir_d;
    end
  end

  cs_token_ring #(.NUM_BLK(NUM_BLK), .COL_W(COL_W)) u_tok (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .load_col(start_col),
    .step(tok_step), .sel(tok_sel)
  );

  cs_write_pipe #(.DATA_W(DATA_W)) u_wp (
    .clk(clk), .rst_n(rst_n), .fire(wr_fire), .din(in_data),
    .wr_en(wp_wr_en), .wr_data(wp_wr_data), .pipe_busy(wp_busy)
  );

  cs_latch_bank #(.DATA_W(DATA_W), .NUM_BLK(NUM_BLK)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wp_wr_en), .wr_sel(tok_sel),
    .wr_data(wp_wr_data), .lanes(lanes)
  );

  cs_read_pipe #(.DATA_W(DATA_W), .NUM_BLK(NUM_BLK), .NUM_QD(NUM_QD)) u_rp (
    .clk(clk), .rst_n(rst_n), .issue(rd_issue), .sel(tok_sel), .lanes(lanes),
    .out_ready(out_ready), .adv(adv), .out_valid(out_valid),
    .out_data(out_data), .pipe_busy(rp_busy)
  );
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
  parameter int DATA_W  = 8,
  parameter int NUM_BLK = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               dir_q,
  input logic [NUM_BLK-1:0] sel,
  input logic               rd_issue,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DATA_W-1:0]  out_data
);
  logic [NUM_BLK-1:0] sel_rot;
  assign sel_rot = {sel[NUM_BLK-2:0], sel[NUM_BLK-1]};

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !in_ready));

  assert_first_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && dir_q) |-> ##3 out_valid);

  assert_single_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(sel) == 1));

  // R3 / R4: each read issue moves the token one lane up, wrapping at the top
  assert_token_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> (sel == $past(sel_rot)));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_write_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !dir_q));
endmodule

bind colstream_top cs_checker #(.DATA_W(DATA_W), .NUM_BLK(NUM_BLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dir_q(dir_q), .sel(tok_sel),
  .rd_issue(rd_issue), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_colstream_top.sv
module tb_colstream_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 64;

  logic       clk, rst_n, start, dir_rd, in_valid, in_ready;
  logic       out_valid, out_ready, busy;
  logic [5:0] start_col;
  logic [6:0] xfer_len;
  logic [7:0] in_data, out_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [NBLK];

  // {start_col[5:0], len[6:0], ready pattern[7:0]}
  localparam logic [20:0] RD_VEC [0:7] = '{
    {6'd0,  7'd64,  8'hFF},
    {6'd5,  7'd10,  8'hAA},
    {6'd63, 7'd3,   8'hFF},
    {6'd17, 7'd1,   8'hFF},
    {6'd30, 7'd40,  8'h6D},
    {6'd48, 7'd20,  8'h0F},
    {6'd10, 7'd100, 8'hFF},
    {6'd40, 7'd33,  8'hB1}
  };

  colstream_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .dir_rd(dir_rd), .xfer_len(xfer_len), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(input int col, input bit rd, input int len);
    @(negedge clk);
    start = 1'b1; start_col = 6'(col); dir_rd = rd; xfer_len = 7'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    while (busy && k < 50) begin @(negedge clk); k++; end
    check(!busy, req, busy, 0);
  endtask

  task automatic run_write(input int col, input int len, input int seed,
                           input bit gap, input string req);
    int n = 0;
    int cyc = 0;
    launch(col, 1'b0, len);
    while (n < len && cyc < 2000) begin
      in_valid = gap ? ((cyc % 3) != 2) : 1'b1;
      in_data  = 8'((seed + n * 29) & 255);
      if (in_valid && in_ready) begin
        model[(col + n) % NBLK] = in_data;
        n++;
      end
      @(negedge clk);
      cyc++;
    end
    check(n == len, req, n, len);
    in_valid = 1'b1;
    check(!in_ready, "R8 in_ready after count", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle("R8 write idle");
  endtask

  task automatic run_read(input int col, input int len, input logic [7:0] pat,
                          input bit inject, input string req);
    int n = 0;
    int cyc = 0;
    bit hold = 0;
    bit injected = 0;
    logic [7:0] hold_d = '0;
    logic [7:0] expv;
    launch(col, 1'b1, len);
    while (n < len && cyc < 4000) begin
      out_ready = pat[cyc % 8];
      if (hold) check(out_valid && out_data == hold_d, "R6 stall hold", out_data, hold_d);
      if (out_valid && out_ready) begin
        expv = model[(col + n) % NBLK];
        check(out_data == expv, req, out_data, expv);
        n++;
      end
      hold   = out_valid && !out_ready;
      hold_d = out_data;
      if (inject && n == 1 && !injected) begin
        injected = 1;
        start = 1'b1; start_col = 6'(col + 7); dir_rd = 1'b1; xfer_len = 7'd5;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(n == len, "R8 read count", n, len);
    out_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check(!out_valid, "R8 no extra byte", out_valid, 0);
      @(negedge clk);
    end
    wait_idle("R8 read idle");
    if (inject) begin
      repeat (6) begin
        check(!busy && !out_valid, "R9 ignored start", busy, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; start_col = '0; dir_rd = 1'b0; xfer_len = '0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    for (int i = 0; i < NBLK; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && !in_ready && !busy, "R1 in reset",
          {out_valid, in_ready, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !in_ready && !busy, "R1 after reset",
          {out_valid, in_ready, busy}, 0);

    // R7: fill every lane through the write stream, then read it back
    run_write(0, 64, 8'h11, 1'b0, "R7 fill count");

    // table walk: reads under several start lanes, counts and ready patterns
    for (int v = 0; v < 8; v++) begin
      run_read(int'(RD_VEC[v][20:15]), int'(RD_VEC[v][14:8]), RD_VEC[v][7:0], 1'b0,
               (int'(RD_VEC[v][20:15]) + int'(RD_VEC[v][14:8]) > NBLK) ?
               "R4 wrap order" : "R3 lane order");
    end

    // R2 latency and R5 one byte per clock
    begin
      int k = 0;
      out_ready = 1'b1;
      launch(5, 1'b1, 6);
      while (!out_valid && k < 20) begin @(negedge clk); k++; end
      check(k == 3, "R2 first byte latency", k, 3);
      for (int i = 0; i < 6; i++) begin
        check(out_valid && out_data == model[5 + i], "R5 back-to-back", out_data, model[5 + i]);
        @(negedge clk);
      end
      check(!out_valid, "R8 stream end", out_valid, 0);
      wait_idle("R8 idle after burst");
    end

    // R4 + R7: a write that wraps past lane 63, gaps in the input stream
    run_write(60, 8, 8'h80, 1'b1, "R7 wrap write count");
    run_read(56, 16, 8'hFF, 1'b0, "R4 wrap write readback");

    // R9: start pulse during a running read
    run_read(20, 20, 8'hFF, 1'b1, "R9 stream order");

    // R8: zero count launches nothing
    launch(3, 1'b1, 0);
    check(!busy, "R8 zero length busy", busy, 0);
    repeat (4) @(negedge clk);
    check(!out_valid && !busy, "R8 zero length output", out_valid, 0);

    summary();
    $finish;
  end
endmodule